// File: doc/BRIEF.md
# Byte-serial Varint decoder

This block turns a stream of variable-length integer bytes back into fixed-width unsigned values. Each byte uses its low seven bits for data and its top bit to say whether more bytes of the same value follow. The decoder takes one byte per clock when `in_valid` is high. It places each seven-bit group above the groups already received, so the first byte supplies the least significant bits. When a byte arrives with its top bit clear, the decoder emits the rebuilt value, together with the number of bytes that value used.

A value of `VALUE_W` bits needs at most `ceil(VALUE_W/7)` bytes. The final permitted byte may carry only the bits still missing from the value, and it must not ask for a further byte. The decoder rejects a final-slot byte that breaks either rule with an error pulse. It then drops the remaining bytes of the broken value and starts a fresh value after the next byte whose top bit is clear. The block never stalls the source. It accepts a byte on every clock, including the clock in which it presents a result.

Top module: `varint_decoder`

## Requirements
- R1: Bit 7 of each accepted byte is the continuation flag and never appears in the result. Only bits 6:0 are payload, and they keep their bit order.
- R2: The payload of the k-th accepted byte of a value (k counted from 0) lands at bit offset 7*k of `out_value`. All result bits above the last received group are zero.
- R3: A byte accepted with bit 7 clear ends the value. In the next cycle `out_valid` is high for exactly that one cycle, `out_value` holds the value, and `out_count` holds the number of bytes accepted for it (1 to 10).
- R4: A byte may be accepted on every clock, including the cycle in which `out_valid` is high. The accumulator and the byte index restart from zero after each completed value, so values sent back to back decode independently.
- R5: The single byte 0x00 decodes to 0 and the single byte 0x01 decodes to 1, each with `out_count` = 1.
- R6: With `VALUE_W` = 64, a tenth byte with bit 7 clear and payload 0x00 or 0x01 is legal. FF repeated nine times followed by 01 decodes to all ones with `out_count` = 10.
- R7: With `VALUE_W` = 64, a tenth byte with bit 7 set or any of bits 6:1 set is malformed. The decoder raises `out_error` for one cycle in the next cycle, and `out_valid` stays low for that value.
- R8: After a malformed tenth byte with bit 7 set, the decoder discards bytes up to and including the next one with bit 7 clear, and produces no output for them. If the malformed byte itself had bit 7 clear, the very next byte already begins a new value.
- R9: A clock with `in_valid` low does not change the decoding state. Bytes presented then are ignored, and a value may arrive with idle gaps between its bytes.
- R10: When `rst_n` is sampled low, `out_valid`, `out_error`, `out_value` and `out_count` become zero and any partly received value is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Encoded byte: bit 7 continuation flag, bits 6:0 payload |
| out_valid | output | 1 | One-cycle pulse: `out_value` and `out_count` hold a new result |
| out_value | output | VALUE_W | Rebuilt unsigned value, held until the next result |
| out_count | output | CNT_W | Bytes used by the value in `out_value` |
| out_error | output | 1 | One-cycle pulse: a malformed final-slot byte was seen |

## Verification
The bench builds the decoder with its default `VALUE_W` of 64, so each value can take up to ten bytes and the final slot has one legal payload bit. This width brings the full range into reach: the longest legal encoding, the all-ones result, and both ways a tenth byte can be malformed. It also covers the discard-and-resynchronise path and a value whose top byte sits at offset 56. Back-to-back vectors exercise acceptance during an output pulse, and directed runs cover idle gaps inside a value and a reset in the middle of a value.

// File: rtl/varint_pkg.sv
// Shared constants and types for the Varint decoder.
// Assumes a fixed 8-bit byte with one flag bit on top of seven payload bits.
package varint_pkg;
    localparam int BYTE_W   = 8;
    localparam int PAY_W    = 7;
    localparam int FLAG_BIT = 7;

    // Decoder mode: collecting groups of a value, or dropping a broken one
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DISCARD = 1'b1
    } dec_state_e;

    // Number of bytes needed to carry a value of the given width
    function automatic int groups_for(input int width);
        return (width + PAY_W - 1) / PAY_W;
    endfunction
endpackage

// File: rtl/varint_lane_place.sv
// Places one 7-bit payload group at bit offset 7*idx of a VALUE_W-wide word.
// Assumes idx < MAX_BYTES; every other bit of the output is zero.
// The top lane is truncated to the bits that remain in the value.
module varint_lane_place
    import varint_pkg::*;
#(
    parameter int VALUE_W   = 64,
    parameter int MAX_BYTES = 10,
    parameter int IDX_W     = 4
) (
    input  logic [PAY_W-1:0]   payload,
    input  logic [IDX_W-1:0]   idx,
    output logic [VALUE_W-1:0] placed
);
    // One lane per byte slot; the lanes cover disjoint bit ranges
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        localparam int LO  = g * PAY_W;
        localparam int WID = (VALUE_W - LO < PAY_W) ? (VALUE_W - LO) : PAY_W;
        assign placed[LO +: WID] = (idx == IDX_W'(g)) ? payload[WID-1:0] : '0;
    end
endmodule

// File: rtl/varint_frame_ctrl.sv
// Tracks the byte slot within the current value and the collect/discard mode.
// Decides, for each accepted byte, whether it extends, completes or breaks
// the value. Assumes in_valid marks an accepted byte (no backpressure).
module varint_frame_ctrl
    import varint_pkg::*;
#(
    parameter int MAX_BYTES = 10,
    parameter int LAST_W    = 1,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             flag,
    input  logic [PAY_W-1:0] payload,
    output logic [IDX_W-1:0] idx,
    output logic             in_collect,
    output logic             extend,
    output logic             complete,
    output logic             bad
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_BYTES - 1);

    dec_state_e state;
    logic       last_slot;
    logic       overrange;

    // Final-slot checks: payload bits beyond the value width are illegal
    always_comb begin
        last_slot = (idx == LAST_IDX);
        overrange = |(payload >> LAST_W);
    end

    // Classify the accepted byte in collect mode
    always_comb begin
        in_collect = (state == ST_COLLECT);
        bad        = in_collect && in_valid && last_slot && (flag || overrange);
        complete   = in_collect && in_valid && !flag && !bad;
        extend     = in_collect && in_valid && flag && !bad;
    end

    // Slot index: advance on extend, restart on complete or error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (extend) begin
            idx <= idx + 1'b1;
        end else if (complete || bad) begin
            idx <= '0;
        end
    end

    // Mode: enter discard on a flagged bad byte, leave on a flag-clear byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else if (bad && flag) begin
            state <= ST_DISCARD;
        end else if ((state == ST_DISCARD) && in_valid && !flag) begin
            state <= ST_COLLECT;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);                                                     // R6
    AST_DISCARD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |-> (idx == '0));                               // R8
    AST_GAP_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(idx));                                          // R9
endmodule

// File: rtl/varint_accum.sv
// Holds the groups of the value being received. Merges the current byte's
// placed payload with the stored groups, and clears after each value ends.
// Assumes the placed input has nonzero bits only in the current slot.
module varint_accum
    import varint_pkg::*;
#(
    parameter int VALUE_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               extend,
    input  logic               finish,
    input  logic [VALUE_W-1:0] placed,
    output logic [VALUE_W-1:0] merged
);
    logic [VALUE_W-1:0] acc;

    // Stored groups plus the group arriving this cycle
    always_comb begin
        merged = acc | placed;
    end

    // Keep groups while a value continues; start empty for the next value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (extend) begin
            acc <= merged;
        end else if (finish) begin
            acc <= '0;
        end
    end
endmodule

// File: rtl/varint_result_reg.sv
// Registers the decoded value and byte count on completion, and produces
// the one-cycle valid and error pulses. Result data holds between values.
module varint_result_reg
    import varint_pkg::*;
#(
    parameter int VALUE_W   = 64,
    parameter int MAX_BYTES = 10,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               complete,
    input  logic               bad,
    input  logic [IDX_W-1:0]   idx,
    input  logic [VALUE_W-1:0] merged,
    output logic               out_valid,
    output logic [VALUE_W-1:0] out_value,
    output logic [CNT_W-1:0]   out_count,
    output logic               out_error
);
    // Pulses last one cycle: they follow the classification of each byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_error <= 1'b0;
        end else begin
            out_valid <= complete;
            out_error <= bad;
        end
    end

    // Capture value and byte count when a value completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_value <= '0;
            out_count <= '0;
        end else if (complete) begin
            out_value <= merged;
            out_count <= CNT_W'(idx) + CNT_W'(1);
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= CNT_W'(1)) && (out_count <= CNT_W'(MAX_BYTES))); // R3
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_count < CNT_W'(MAX_BYTES)))
            |-> ((out_value >> (PAY_W * int'(out_count))) == '0));            // R2
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_error));                                           // R7
endmodule

// File: rtl/varint_decoder.sv
// Byte-serial Varint decoder top. Splits each byte into flag and payload,
// places the payload by slot, accumulates, and reports the finished value,
// its byte count, and malformed final-slot bytes. One byte per clock, never
// stalls; synchronous active-low reset.
module varint_decoder
    import varint_pkg::*;
#(
    parameter int VALUE_W = 64,
    localparam int MAX_BYTES = groups_for(VALUE_W),
    localparam int LAST_W    = VALUE_W - PAY_W * (MAX_BYTES - 1),
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    output logic               out_valid,
    output logic [VALUE_W-1:0] out_value,
    output logic [CNT_W-1:0]   out_count,
    output logic               out_error
);
    logic               flag;
    logic [PAY_W-1:0]   payload;
    logic [IDX_W-1:0]   idx;
    logic               in_collect;
    logic               extend;
    logic               complete;
    logic               bad;
    logic [VALUE_W-1:0] placed;
    logic [VALUE_W-1:0] merged;

    // Separate the continuation flag from the payload group
    always_comb begin
        flag    = in_byte[FLAG_BIT];
        payload = in_byte[PAY_W-1:0];
    end

    varint_frame_ctrl #(
        .MAX_BYTES (MAX_BYTES),
        .LAST_W    (LAST_W),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .flag       (flag),
        .payload    (payload),
        .idx        (idx),
        .in_collect (in_collect),
        .extend     (extend),
        .complete   (complete),
        .bad        (bad)
    );

    varint_lane_place #(
        .VALUE_W   (VALUE_W),
        .MAX_BYTES (MAX_BYTES),
        .IDX_W     (IDX_W)
    ) u_place (
        .payload (payload),
        .idx     (idx),
        .placed  (placed)
    );

    varint_accum #(
        .VALUE_W (VALUE_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .extend (extend),
        .finish (complete || bad),
        .placed (placed),
        .merged (merged)
    );

    varint_result_reg #(
        .VALUE_W   (VALUE_W),
        .MAX_BYTES (MAX_BYTES),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .bad       (bad),
        .idx       (idx),
        .merged    (merged),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_count (out_count),
        .out_error (out_error)
    );

    AST_SINGLE_BYTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_byte[FLAG_BIT] && in_collect && (idx == '0))
            |=> (out_valid && (out_count == CNT_W'(1))));                     // R5
    AST_ERROR_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_error |-> ($past(idx) == IDX_W'(MAX_BYTES - 1)));                 // R7
    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_collect |=> (!out_valid && !out_error));                          // R8
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_error));                            // R9
    AST_FLAG_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte[FLAG_BIT]) |=> !out_valid);                      // R3
endmodule

// File: tb/varint_decoder_test.sv
`timescale 1ns/1ps
module varint_decoder_test;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_valid;
    logic [63:0] out_value;
    logic [3:0]  out_count;
    logic        out_error;

    logic        o_valid;
    logic        o_err;
    logic [63:0] o_val;
    logic [3:0]  o_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // First byte of each vector in bits [7:0]
    localparam logic [79:0] VEC_BYTES [NV] = '{
        80'h0000_0000_0000_0000_0001,
        80'h0000_0000_0000_0000_0000,
        80'h0000_0004_BB93_9DA7_98B3,
        80'h0000_0000_0000_0000_0196,
        80'h01FF_FFFF_FFFF_FFFF_FFFF,
        80'h0000_0000_0000_0000_0080,
        80'h0000_0000_0000_007F_FFFF,
        80'h0001_8080_8080_8080_8080
    };
    localparam int VEC_LEN [NV] = '{1, 1, 7, 2, 10, 2, 3, 9};
    localparam logic [63:0] VEC_VAL [NV] = '{
        64'h0000_0000_0000_0001,
        64'h0000_0000_0000_0000,
        64'h0000_11D9_33A9_CC33,
        64'h0000_0000_0000_0096,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0000,
        64'h0000_0000_001F_FFFF,
        64'h0100_0000_0000_0000
    };

    varint_decoder #(.VALUE_W(64)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_count (out_count),
        .out_error (out_error)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // At a falling edge: capture outputs of the last rising edge, then drive
    task automatic cycle(input logic v, input logic [7:0] b);
        @(negedge clk);
        o_valid  = out_valid;
        o_err    = out_error;
        o_val    = out_value;
        o_cnt    = out_count;
        in_valid = v;
        in_byte  = b;
    endtask

    task automatic expect_value(input string req, input logic [63:0] v, input int n);
        check({req, " valid"}, 64'(o_valid), 64'd1);
        check({req, " value"}, o_val, v);
        check({req, " count"}, 64'(o_cnt), 64'(n));
        check({req, " error"}, 64'(o_err), 64'd0);
    endtask

    task automatic send_nine_ff();
        for (int k = 0; k < 9; k++) cycle(1'b1, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        cycle(1'b0, 8'h00);
        check("R10 valid", 64'(o_valid), 64'd0);
        check("R10 error", 64'(o_err), 64'd0);
        check("R10 value", o_val, 64'd0);
        check("R10 count", 64'(o_cnt), 64'd0);

        // R1 R2 R3 R4 R5 R6: vectors sent back to back; each result is
        // checked in the cycle that also delivers the next first byte
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < VEC_LEN[i]; j++) begin
                cycle(1'b1, VEC_BYTES[i][8*j +: 8]);
                if (j == 0 && i > 0)
                    expect_value("R1 R2 R3 R4", VEC_VAL[i-1], VEC_LEN[i-1]);
                else if (j > 0)
                    check("R3 no early valid", 64'(o_valid), 64'd0);
            end
        end
        cycle(1'b0, 8'h00);
        expect_value("R2 R3", VEC_VAL[NV-1], VEC_LEN[NV-1]);
        cycle(1'b0, 8'h00);
        check("R3 single pulse", 64'(o_valid), 64'd0);

        // R9: idle gaps inside a value are ignored
        cycle(1'b1, 8'h96);
        cycle(1'b0, 8'hFF);
        cycle(1'b0, 8'h00);
        check("R9 no output in gap", 64'(o_valid), 64'd0);
        cycle(1'b0, 8'h7F);
        cycle(1'b1, 8'h01);
        cycle(1'b0, 8'h00);
        expect_value("R9", 64'd150, 2);

        // R7 R8: tenth byte with flag set, then discard and resync
        send_nine_ff();
        cycle(1'b1, 8'h81);
        cycle(1'b1, 8'h85);
        check("R7 error pulse", 64'(o_err), 64'd1);
        check("R7 no valid", 64'(o_valid), 64'd0);
        cycle(1'b1, 8'h05);
        check("R7 error one cycle", 64'(o_err), 64'd0);
        cycle(1'b1, 8'h07);
        check("R8 discard silent valid", 64'(o_valid), 64'd0);
        check("R8 discard silent error", 64'(o_err), 64'd0);
        cycle(1'b0, 8'h00);
        expect_value("R8", 64'd7, 1);

        // R7 R8: tenth byte with payload bit 1 set and flag clear
        send_nine_ff();
        cycle(1'b1, 8'h02);
        cycle(1'b1, 8'h01);
        check("R7 overrange error", 64'(o_err), 64'd1);
        check("R7 overrange no valid", 64'(o_valid), 64'd0);
        cycle(1'b0, 8'h00);
        expect_value("R8 immediate resync", 64'd1, 1);

        // R10: reset in the middle of a value abandons it
        cycle(1'b1, 8'hFE);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b1, 8'h05);
        check("R10 cleared value", o_val, 64'd0);
        cycle(1'b0, 8'h00);
        expect_value("R10 after reset", 64'd5, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule